// File: doc/BRIEF.md
# RV32I Control Signal Decoder

This block turns one 32-bit RV32I instruction word into the control signals of a single-cycle datapath. It classifies the word by its 7-bit major opcode. It then sets the program-counter behaviour, the register-file and memory write enables, the write-back source, the ALU operand-B source and the ALU operation. It also emits a 3-bit immediate-format code, which tells the companion immediate extender how to gather and sign-extend the immediate bits.

The decoder has no clock and no state, and every output follows the present instruction word. It covers register-register and register-immediate ALU operations, word load, word store, conditional branches, jal, lui and auipc. Any other major opcode falls back to a safe default: sequential PC, no write of any kind, and a load-free write-back path. Branch comparison, the ALU, the register file and the memories belong to the surrounding datapath.

Top module: `rvdec_top`

## Requirements
- R1: The block is purely combinational. Every output is a function of the present `instr` value alone, and a new word is reflected without any clock edge. The field positions are fixed: opcode is bits [6:0], funct3 is bits [14:12], and the arithmetic-variant bit is bit 30 (bit 5 of funct7 in bits [31:25]).
- R2: Opcode 0110011 (register-register) gives reg_write=1, alu_src_b=0 (rs2), mem_write=0, mem_to_reg=0, pc_sel=00, jump=0 and imm_src=000. Word 32'h01248AB3 decodes as add.
- R3: Opcode 0010011 (register-immediate) gives reg_write=1, alu_src_b=1 (immediate), imm_src=000 (I format), mem_write=0 and pc_sel=00. Bit 30 selects arithmetic shift only when funct3=101. For every other funct3 it has no effect, so 32'hF9CA8A93 (bit 30 set) still decodes as add.
- R4: alu_op codes are add 0, sub 1, sll 2, slt 3, sltu 4, xor 5, srl 6, sra 7, or 8, and 9, pass-B 10. For ALU opcodes, funct3 maps 000 to add, 001 to sll, 010 to slt, 011 to sltu, 100 to xor, 101 to srl, 110 to or and 111 to and. In the register-register form, bit 30 turns add into sub and srl into sra.
- R5: Opcode 0000011 (load) gives mem_to_reg=1, reg_write=1, alu_src_b=1, imm_src=000, alu_op=add and mem_write=0.
- R6: Opcode 0100011 (store) gives mem_write=1, reg_write=0, alu_src_b=1, imm_src=001 (S format), alu_op=add and mem_to_reg=0.
- R7: Opcode 1100011 (branch) gives pc_sel=01, jump=0, reg_write=0, mem_write=0, imm_src=010 (B format), alu_src_b=0 and alu_op=sub.
- R8: Opcode 1101111 (jal) gives pc_sel=10, jump=1, reg_write=1, imm_src=100 (J format), alu_src_b=0, alu_op=add and mem_write=0.
- R9: Opcode 0110111 (lui) gives reg_write=1, alu_src_b=1, imm_src=011 (U format) and alu_op=pass-B. Opcode 0010111 (auipc) gives the same, except that alu_op=add.
- R10: Any other opcode gives pc_sel=00, jump=0, reg_write=0, mem_write=0, mem_to_reg=0, alu_src_b=0, imm_src=000 and alu_op=add.
- R11: jump is 1 exactly when pc_sel=10, and pc_sel never takes the value 11.
- R12: The register-index fields (bits [11:7], [19:15], [24:20]) and the funct7 bits other than bit 30 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| pc_sel | output | 2 | PC behaviour: 00 sequential +4, 01 conditional branch, 10 jump |
| jump | output | 1 | Unconditional jump flag |
| mem_to_reg | output | 1 | Write-back takes memory read data |
| mem_write | output | 1 | Data memory write enable |
| alu_op | output | 4 | ALU operation code |
| alu_src_b | output | 1 | ALU operand B: 0 register rs2, 1 extended immediate |
| imm_src | output | 3 | Immediate format code for the extender |
| reg_write | output | 1 | Register file write enable |

## Verification
The sweep steps through all 128 opcode values against all eight funct3 values, with bit 30 both clear and set. This separates every opcode class from its neighbours and from the undefined space, and separates each ALU function from the others. Each point is repeated with the non-decoded bits all zero, all one and in a mixed pattern, which shows that register indices and the other funct7 bits leak into nothing. Two fixed words, an add and an addi with a negative immediate (bit 30 set), pin down the cases where the variant bit must be ignored or honoured.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam int ILEN  = 32;
    localparam int OPC_W = 7;
    localparam int F3_W  = 3;
    localparam int PCS_W = 2;
    localparam int IMM_W = 3;
    localparam int AOP_W = 4;
    localparam int ALT_BIT = 30;

    localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;

    typedef enum logic [PCS_W-1:0] {
        PCS_SEQ    = 2'b00,
        PCS_BRANCH = 2'b01,
        PCS_JUMP   = 2'b10
    } pcs_e;

    typedef enum logic [IMM_W-1:0] {
        IMMF_I = 3'd0,
        IMMF_S = 3'd1,
        IMMF_B = 3'd2,
        IMMF_U = 3'd3,
        IMMF_J = 3'd4
    } immf_e;

    typedef enum logic [AOP_W-1:0] {
        AOP_ADD   = 4'd0,
        AOP_SUB   = 4'd1,
        AOP_SLL   = 4'd2,
        AOP_SLT   = 4'd3,
        AOP_SLTU  = 4'd4,
        AOP_XOR   = 4'd5,
        AOP_SRL   = 4'd6,
        AOP_SRA   = 4'd7,
        AOP_OR    = 4'd8,
        AOP_AND   = 4'd9,
        AOP_PASSB = 4'd10
    } aop_e;

    typedef enum logic [3:0] {
        CLS_NONE,
        CLS_REG,
        CLS_IMM,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JAL,
        CLS_LUI,
        CLS_AUIPC
    } cls_e;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [F3_W-1:0]  funct3;
        logic             alt;
    } fields_t;

    typedef struct packed {
        pcs_e  pcs;
        logic  jump;
        logic  mem_to_reg;
        logic  mem_write;
        logic  src_b_imm;
        logic  reg_write;
        immf_e imm_fmt;
    } main_ctl_t;

endpackage

// File: rtl/rvdec_fields.sv
module rvdec_fields
    import rvdec_pkg::*;
(
    input  logic [ILEN-1:0] word_i,
    output fields_t         fields_o
);

    localparam int F3_LO = 12;

    // register indices and the remaining funct7 bits are not decoded
    logic unused_bits;
    assign unused_bits = ^{word_i[ILEN-1], word_i[ALT_BIT-1:F3_LO+F3_W],
                           word_i[F3_LO-1:OPC_W]};

    assign fields_o.opcode = word_i[OPC_W-1:0];
    assign fields_o.funct3 = word_i[F3_LO+F3_W-1:F3_LO];
    assign fields_o.alt    = word_i[ALT_BIT];

endmodule

// File: rtl/rvdec_main.sv
module rvdec_main
    import rvdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output cls_e             cls_o,
    output main_ctl_t        ctl_o
);

    always_comb begin
        unique case (opcode_i)
            OPC_REG:    cls_o = CLS_REG;
            OPC_IMM:    cls_o = CLS_IMM;
            OPC_LOAD:   cls_o = CLS_LOAD;
            OPC_STORE:  cls_o = CLS_STORE;
            OPC_BRANCH: cls_o = CLS_BRANCH;
            OPC_JAL:    cls_o = CLS_JAL;
            OPC_LUI:    cls_o = CLS_LUI;
            OPC_AUIPC:  cls_o = CLS_AUIPC;
            default:    cls_o = CLS_NONE;
        endcase
    end

    always_comb begin
        ctl_o.pcs        = PCS_SEQ;
        ctl_o.jump       = 1'b0;
        ctl_o.mem_to_reg = 1'b0;
        ctl_o.mem_write  = 1'b0;
        ctl_o.src_b_imm  = 1'b0;
        ctl_o.reg_write  = 1'b0;
        ctl_o.imm_fmt    = IMMF_I;
        unique case (cls_o)
            CLS_REG: begin
                ctl_o.reg_write = 1'b1;
            end
            CLS_IMM: begin
                ctl_o.reg_write = 1'b1;
                ctl_o.src_b_imm = 1'b1;
            end
            CLS_LOAD: begin
                ctl_o.reg_write  = 1'b1;
                ctl_o.src_b_imm  = 1'b1;
                ctl_o.mem_to_reg = 1'b1;
            end
            CLS_STORE: begin
                ctl_o.mem_write = 1'b1;
                ctl_o.src_b_imm = 1'b1;
                ctl_o.imm_fmt   = IMMF_S;
            end
            CLS_BRANCH: begin
                ctl_o.pcs     = PCS_BRANCH;
                ctl_o.imm_fmt = IMMF_B;
            end
            CLS_JAL: begin
                ctl_o.pcs       = PCS_JUMP;
                ctl_o.jump      = 1'b1;
                ctl_o.reg_write = 1'b1;
                ctl_o.imm_fmt   = IMMF_J;
            end
            CLS_LUI, CLS_AUIPC: begin
                ctl_o.reg_write = 1'b1;
                ctl_o.src_b_imm = 1'b1;
                ctl_o.imm_fmt   = IMMF_U;
            end
            default: begin
                ctl_o.pcs = PCS_SEQ;
            end
        endcase
    end

endmodule

// File: rtl/rvdec_alu.sv
module rvdec_alu
    import rvdec_pkg::*;
(
    input  cls_e            cls_i,
    input  logic [F3_W-1:0] funct3_i,
    input  logic            alt_i,
    output aop_e            aop_o
);

    function automatic aop_e map_f3(input logic [F3_W-1:0] f3,
                                    input logic sub_ok, input logic sra_ok);
        aop_e r;
        unique case (f3)
            3'b000:  r = sub_ok ? AOP_SUB : AOP_ADD;
            3'b001:  r = AOP_SLL;
            3'b010:  r = AOP_SLT;
            3'b011:  r = AOP_SLTU;
            3'b100:  r = AOP_XOR;
            3'b101:  r = sra_ok ? AOP_SRA : AOP_SRL;
            3'b110:  r = AOP_OR;
            default: r = AOP_AND;
        endcase
        return r;
    endfunction

    always_comb begin
        unique case (cls_i)
            CLS_REG:    aop_o = map_f3(funct3_i, alt_i, alt_i);
            CLS_IMM:    aop_o = map_f3(funct3_i, 1'b0, alt_i);
            CLS_BRANCH: aop_o = AOP_SUB;
            CLS_LUI:    aop_o = AOP_PASSB;
            default:    aop_o = AOP_ADD;
        endcase
    end

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
    import rvdec_pkg::*;
(
    input  logic [31:0] instr,
    output logic [1:0]  pc_sel,
    output logic        jump,
    output logic        mem_to_reg,
    output logic        mem_write,
    output logic [3:0]  alu_op,
    output logic        alu_src_b,
    output logic [2:0]  imm_src,
    output logic        reg_write
);

    fields_t   fld;
    cls_e      cls;
    main_ctl_t ctl;
    aop_e      aop;

    rvdec_fields u_fields (
        .word_i   (instr),
        .fields_o (fld)
    );

    rvdec_main u_main (
        .opcode_i (fld.opcode),
        .cls_o    (cls),
        .ctl_o    (ctl)
    );

    rvdec_alu u_alu (
        .cls_i    (cls),
        .funct3_i (fld.funct3),
        .alt_i    (fld.alt),
        .aop_o    (aop)
    );

    assign pc_sel     = ctl.pcs;
    assign jump       = ctl.jump;
    assign mem_to_reg = ctl.mem_to_reg;
    assign mem_write  = ctl.mem_write;
    assign alu_op     = aop;
    assign alu_src_b  = ctl.src_b_imm;
    assign imm_src    = ctl.imm_fmt;
    assign reg_write  = ctl.reg_write;

endmodule

// File: rtl/rvdec_check.sv
module rvdec_check
    import rvdec_pkg::*;
(
    input logic [31:0] instr,
    input logic [1:0]  pc_sel,
    input logic        jump,
    input logic        mem_to_reg,
    input logic        mem_write,
    input logic [3:0]  alu_op,
    input logic        alu_src_b,
    input logic [2:0]  imm_src,
    input logic        reg_write
);

    logic [OPC_W-1:0] op;
    logic             known;
    logic             unused_chk;

    assign op = instr[OPC_W-1:0];
    assign unused_chk = ^instr[31:OPC_W];
    assign known = (op == OPC_REG) || (op == OPC_IMM) || (op == OPC_LOAD) ||
                   (op == OPC_STORE) || (op == OPC_BRANCH) || (op == OPC_JAL) ||
                   (op == OPC_LUI) || (op == OPC_AUIPC);

    always_comb begin
        AST_REG_SRC_RS2: assert (op != OPC_REG || !alu_src_b) else $error("reg form uses immediate"); // R2
        AST_LOAD_WB: assert (!mem_to_reg || (op == OPC_LOAD && reg_write)) else $error("mem_to_reg off load"); // R5
        AST_STORE_NO_RF: assert (op != OPC_STORE || (!reg_write && mem_write)) else $error("store control"); // R6
        AST_BRANCH_NO_RF: assert (op != OPC_BRANCH || (!reg_write && alu_op == AOP_SUB)) else $error("branch control"); // R7
        AST_LUI_PASS: assert (op != OPC_LUI || (alu_op == AOP_PASSB && imm_src == IMMF_U)) else $error("lui control"); // R9
        AST_UNDEF_SAFE: assert (known || (!reg_write && !mem_write && pc_sel == PCS_SEQ)) else $error("undefined not safe"); // R10
        AST_JUMP_PCS: assert (jump == (pc_sel == PCS_JUMP)) else $error("jump mismatch"); // R11
        AST_PCS_LEGAL: assert (pc_sel != 2'b11) else $error("illegal pc_sel"); // R11
    end

endmodule

bind rvdec_top rvdec_check u_check (
    .instr      (instr),
    .pc_sel     (pc_sel),
    .jump       (jump),
    .mem_to_reg (mem_to_reg),
    .mem_write  (mem_write),
    .alu_op     (alu_op),
    .alu_src_b  (alu_src_b),
    .imm_src    (imm_src),
    .reg_write  (reg_write)
);

// File: tb/rvdec_top_test.sv
module rvdec_top_test;

    logic        clk = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [1:0]  pc_sel;
    logic        jump, mem_to_reg, mem_write, alu_src_b, reg_write;
    logic [3:0]  alu_op;
    logic [2:0]  imm_src;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    rvdec_top uut (
        .instr      (instr),
        .pc_sel     (pc_sel),
        .jump       (jump),
        .mem_to_reg (mem_to_reg),
        .mem_write  (mem_write),
        .alu_op     (alu_op),
        .alu_src_b  (alu_src_b),
        .imm_src    (imm_src),
        .reg_write  (reg_write)
    );

    // packed {pc_sel, jump, mem_to_reg, mem_write, alu_op, alu_src_b, imm_src, reg_write}
    function automatic logic [13:0] model(input logic [31:0] w);
        logic [6:0] op;
        logic [2:0] f3;
        logic       alt;
        logic [1:0] pcs;
        logic       j, m2r, mw, sb, rw;
        logic [2:0] imm;
        logic [3:0] alu, fn;
        op = w[6:0]; f3 = w[14:12]; alt = w[30];
        pcs = 2'b00; j = 0; m2r = 0; mw = 0; sb = 0; rw = 0; imm = 3'd0; alu = 4'd0;
        fn = (f3 == 3'd0) ? 4'd0 : (f3 <= 3'd5) ? {1'b0, f3} + 4'd1 : {1'b0, f3} + 4'd2;
        case (op)
            7'h33: begin rw = 1; alu = (alt && f3 == 3'd0) ? 4'd1 : (alt && f3 == 3'd5) ? 4'd7 : fn; end
            7'h13: begin rw = 1; sb = 1; alu = (alt && f3 == 3'd5) ? 4'd7 : fn; end
            7'h03: begin rw = 1; sb = 1; m2r = 1; end
            7'h23: begin mw = 1; sb = 1; imm = 3'd1; end
            7'h63: begin pcs = 2'b01; imm = 3'd2; alu = 4'd1; end
            7'h6F: begin pcs = 2'b10; j = 1; rw = 1; imm = 3'd4; end
            7'h37: begin rw = 1; sb = 1; imm = 3'd3; alu = 4'd10; end
            7'h17: begin rw = 1; sb = 1; imm = 3'd3; end
            default: ;
        endcase
        return {pcs, j, m2r, mw, alu, sb, imm, rw};
    endfunction

    function automatic string tag_of(input logic [6:0] op);
        case (op)
            7'h33:   return "R2 R4 R12";
            7'h13:   return "R3 R4 R12";
            7'h03:   return "R5 R12";
            7'h23:   return "R6 R12";
            7'h63:   return "R7 R12";
            7'h6F:   return "R8 R12";
            7'h37:   return "R9 R12";
            7'h17:   return "R9 R12";
            default: return "R10 R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s instr=%h actual=%b expected=%b", tag, instr, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [31:0] w, input string tag);
        logic [13:0] outs;
        @(negedge clk);
        instr = w;
        #1;
        outs = {pc_sel, jump, mem_to_reg, mem_write, alu_op, alu_src_b, imm_src, reg_write};
        check(tag, outs, model(w));
        // R11: jump flag tracks the jump PC selection, value 11 never appears
        check("R11", {12'd0, jump, pc_sel == 2'b11}, {12'd0, pc_sel == 2'b10, 1'b0});
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] fill [3];
        fill[0] = 32'h0000_0000;
        fill[1] = 32'hFFFF_FFFF;
        fill[2] = 32'h9B3D_5EA6;

        // R10: the initial all-zero word is an undefined opcode
        #1;
        check("R10 initial", {pc_sel, jump, mem_to_reg, mem_write, alu_op, alu_src_b, imm_src, reg_write},
              14'd0);

        // R2: add x21,x9,x18 -> alu add, rs2 operand
        apply_and_check(32'h01248AB3, "R2 add word");
        check("R2 add alu_op", {10'd0, alu_op}, 14'd0);
        // R3: addi with bit 30 set stays add and uses the I-format immediate
        apply_and_check(32'hF9CA8A93, "R3 addi word");
        check("R3 addi alu/src/imm", {7'd0, alu_op, alu_src_b, imm_src}, {7'd0, 4'd0, 1'b1, 3'd0});
        // R1: a new word shows up without any clock edge
        @(posedge clk);
        #0.5;
        instr = 32'h40000033;
        #0.5;
        check("R1 comb sub", {10'd0, alu_op}, 14'd1);

        for (int op = 0; op < 128; op++) begin
            for (int f3 = 0; f3 < 8; f3++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int k = 0; k < 3; k++) begin
                        logic [31:0] w;
                        w = (fill[k] & ~32'h4000_707F) | (32'(a) << 30) |
                            (32'(f3) << 12) | 32'(op);
                        apply_and_check(w, tag_of(7'(op)));
                    end
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule